// File: doc/BRIEF.md
# Saturating Doubling Widening Multiply-Accumulate

This block is a packed-lane SIMD datapath for signed fixed-point arithmetic. It takes two 64-bit source vectors and a 128-bit accumulator vector. Each source lane is multiplied by the matching lane of the other source, giving a signed product of twice the lane width. The product is then doubled with signed saturation. One of three operations follows: the doubled product is returned as is, it is added to the matching accumulator lane, or it is subtracted from that lane. The add and the subtract both saturate at the result width.

The caller presents one operation per cycle under `in_valid`. An operation has a 4-bit opcode, a 2-bit lane-size code and an unsigned-form bit. One cycle later the block returns three registered values: the 128-bit vector of double-width lanes, a flag for combinations it does not execute, and a sticky saturation flag. Software clears the saturation flag with `sat_clr`. Each 32-bit half of a source produces one 64-bit half of the result, so lanes never cross that boundary.

Top module: `sat_dbl_mac`

## Requirements
- R1: Opcode 4'b1101 returns the doubled product, 4'b1001 adds it to the accumulator lane, and 4'b1011 subtracts it from the accumulator lane. Each of these executes only when `uns` is 0.
- R2: The operation is flagged undefined (`undef`=1, `result`=0, `sat_flag` not set by it) in four cases: `uns` is 1, size is 2'd0, size is 2'd3, or the opcode is none of the three above. A legal operation sets `undef` to 0.
- R3: Size 2'd1 selects four 16-bit lanes. Lane i is `src_a[16i+:16]` and `src_b[16i+:16]`, and its 32-bit result goes to `result[32i+:32]` with accumulator lane `acc[32i+:32]`. Size 2'd2 selects two 32-bit lanes at `[32i+:32]`, and each 64-bit result goes to `result[64i+:64]` with accumulator lane `acc[64i+:64]`.
- R4: The signed product is doubled with saturation at the result width. Only the most negative value times the most negative value saturates, and it gives the most positive result value.
- R5: The accumulate form adds the doubled product to the accumulator lane. A positive overflow clamps to the most positive value and a negative overflow clamps to the most negative value.
- R6: The subtract form negates the doubled product and adds the negated value to the accumulator lane, with the same clamping.
- R7: `sat_flag` is set after a legal operation in which any lane saturated, either in the doubling or in the accumulate/subtract step.
- R8: `sat_flag` stays set until `sat_clr` is sampled high. A clear with no saturating operation in the same cycle gives 0. A clear together with a saturating operation leaves the flag set.
- R9: `out_valid`, `result` and `undef` update one clock edge after `in_valid`. `out_valid` is low after a cycle without `in_valid`, and `result` and `undef` then hold their values.
- R10: After reset, `out_valid`, `result`, `undef` and `sat_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| size | input | 2 | Source lane size code |
| uns | input | 1 | Unsigned-form bit; must be 0 |
| src_a | input | 64 | First source vector |
| src_b | input | 64 | Second source vector |
| acc | input | 128 | Accumulator vector |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Registered result is new |
| result | output | 128 | Double-width lane results |
| sat_flag | output | 1 | Sticky saturation flag |
| undef | output | 1 | Operation not executed |

## Verification
Each lane width is swept over all ordered pairs from a set of boundary operands: both extremes, one above the minimum, -1, 0, small positives and an arbitrary value. Each pair is combined with accumulator patterns that rotate through zero, both extremes and a mid value, under all three opcodes. The minimum-times-minimum pairs separate doubling saturation from accumulate saturation. The extreme accumulators separate positive clamping from negative clamping and show which way the subtract form goes. Putting different pairs in different lanes exposes lane placement and mix-ups between the two halves. Separate directed sequences cover the undefined combinations, the stickiness and clearing of the flag, and the holding of the output.

// File: rtl/sat_dbl_mac.sv
module sat_dbl_mac #(
  parameter int SRC_W = 64,
  parameter int CHUNK_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [3:0]           op,
  input  logic [1:0]           size,
  input  logic                 uns,
  input  logic [SRC_W-1:0]     src_a,
  input  logic [SRC_W-1:0]     src_b,
  input  logic [2*SRC_W-1:0]   acc,
  input  logic                 sat_clr,
  output logic                 out_valid,
  output logic [2*SRC_W-1:0]   result,
  output logic                 sat_flag,
  output logic                 undef
);
  localparam int NCH = SRC_W / CHUNK_W;
  localparam int HW  = CHUNK_W / 2;
  localparam int WW  = 2 * CHUNK_W;
  localparam int NW  = CHUNK_W;

  function automatic logic [WW:0] sadd_w(input logic [WW-1:0] x, input logic [WW-1:0] y);
    logic [WW-1:0] s;
    logic ov;
    s  = x + y;
    ov = (x[WW-1] == y[WW-1]) && (s[WW-1] != x[WW-1]);
    if (ov) s = x[WW-1] ? {1'b1, {(WW-1){1'b0}}} : {1'b0, {(WW-1){1'b1}}};
    return {ov, s};
  endfunction

  function automatic logic [NW:0] sadd_n(input logic [NW-1:0] x, input logic [NW-1:0] y);
    logic [NW-1:0] s;
    logic ov;
    s  = x + y;
    ov = (x[NW-1] == y[NW-1]) && (s[NW-1] != x[NW-1]);
    if (ov) s = x[NW-1] ? {1'b1, {(NW-1){1'b0}}} : {1'b0, {(NW-1){1'b1}}};
    return {ov, s};
  endfunction

  wire is_mla = (op == 4'b1001);
  wire is_mls = (op == 4'b1011);
  wire is_mul = (op == 4'b1101);
  wire wide   = (size == 2'd2);
  wire legal  = !uns && (size == 2'd1 || wide) && (is_mla || is_mls || is_mul);

  logic [2*SRC_W-1:0] res_c;
  logic [NCH-1:0]     sat_c;

  for (genvar g = 0; g < NCH; g++) begin : g_chunk
    logic signed [CHUNK_W-1:0] wa, wb;
    logic signed [WW-1:0]      wprod;
    logic [WW:0]               wdbl, wfin;
    logic [WW-1:0]             wacc;
    logic [WW-1:0]             nres;
    logic [1:0]                nsat;

    assign wa    = src_a[g*CHUNK_W +: CHUNK_W];
    assign wb    = src_b[g*CHUNK_W +: CHUNK_W];
    assign wprod = wa * wb;
    assign wdbl  = sadd_w(wprod, wprod);
    assign wacc  = acc[g*WW +: WW];
    assign wfin  = is_mla ? sadd_w(wacc, wdbl[WW-1:0]) :
                   is_mls ? sadd_w(wacc, -wdbl[WW-1:0]) : {1'b0, wdbl[WW-1:0]};

    for (genvar k = 0; k < 2; k++) begin : g_lane
      logic signed [HW-1:0] na, nb;
      logic signed [NW-1:0] nprod;
      logic [NW:0]          ndbl, nfin;
      logic [NW-1:0]        nacc;

      assign na    = src_a[g*CHUNK_W + k*HW +: HW];
      assign nb    = src_b[g*CHUNK_W + k*HW +: HW];
      assign nprod = na * nb;
      assign ndbl  = sadd_n(nprod, nprod);
      assign nacc  = acc[g*WW + k*NW +: NW];
      assign nfin  = is_mla ? sadd_n(nacc, ndbl[NW-1:0]) :
                     is_mls ? sadd_n(nacc, -ndbl[NW-1:0]) : {1'b0, ndbl[NW-1:0]};
      assign nres[k*NW +: NW] = nfin[NW-1:0];
      assign nsat[k] = ndbl[NW] | nfin[NW];
    end

    assign res_c[g*WW +: WW] = wide ? wfin[WW-1:0] : nres;
    assign sat_c[g] = wide ? (wdbl[WW] | wfin[WW]) : |nsat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      undef     <= 1'b0;
      sat_flag  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      sat_flag  <= (sat_flag & ~sat_clr) | (in_valid & legal & |sat_c);
      if (in_valid) begin
        result <= legal ? res_c : '0;
        undef  <= !legal;
      end
    end
  end
endmodule

module sat_dbl_mac_chk #(
  parameter int RW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          uns,
  input logic [1:0]    size,
  input logic          sat_clr,
  input logic          out_valid,
  input logic [RW-1:0] result,
  input logic          sat_flag,
  input logic          undef
);
  // R2
  uns_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && uns) |=> undef);
  // R2
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (size == 2'd0 || size == 2'd3)) |=> undef);
  // R2
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && undef) |-> (result == '0));
  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(undef)));
  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !in_valid) |=> !sat_flag);
endmodule

bind sat_dbl_mac sat_dbl_mac_chk #(.RW(2*SRC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .uns(uns), .size(size),
  .sat_clr(sat_clr), .out_valid(out_valid), .result(result),
  .sat_flag(sat_flag), .undef(undef)
);

// File: tb/test_sat_dbl_mac.sv
module test_sat_dbl_mac;
  localparam int PERIOD = 10;
  localparam logic [3:0] OP_MLA = 4'b1001;
  localparam logic [3:0] OP_MLS = 4'b1011;
  localparam logic [3:0] OP_MUL = 4'b1101;

  logic clk = 0, rst_n = 0, in_valid = 0, uns = 0, sat_clr = 0;
  logic [3:0] op = 0;
  logic [1:0] size = 0;
  logic [63:0] src_a = 0, src_b = 0;
  logic [127:0] acc = 0;
  logic out_valid, sat_flag, undef;
  logic [127:0] result;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  sat_dbl_mac i_sat_dbl_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .uns(uns), .src_a(src_a), .src_b(src_b), .acc(acc), .sat_clr(sat_clr),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag), .undef(undef)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void lane_mdl(input longint av, input longint bv, input longint cv,
                                   input int rw, input logic [3:0] o,
                                   output logic signed [127:0] r, output logic s);
    logic signed [127:0] mx, mn, p, t, d;
    mx = (128'sd1 <<< (rw - 1)) - 128'sd1;
    mn = -mx - 128'sd1;
    s = 0;
    p = av; t = bv;
    d = p * t;
    d = d + d;
    if (d > mx) begin d = mx; s = 1; end
    r = d;
    if (o != OP_MUL) begin
      t = cv;
      t = (o == OP_MLA) ? t + d : t - d;
      if (t > mx) begin t = mx; s = 1; end
      if (t < mn) begin t = mn; s = 1; end
      r = t;
    end
  endfunction

  function automatic void vec_mdl(input logic [3:0] o, input logic [1:0] sz,
                                  input logic [63:0] a, input logic [63:0] b, input logic [127:0] c,
                                  output logic [127:0] res, output logic sat);
    logic signed [127:0] r;
    logic s;
    res = '0; sat = 0;
    if (sz == 2'd1) begin
      for (int i = 0; i < 4; i++) begin
        lane_mdl(longint'($signed(a[16*i +: 16])), longint'($signed(b[16*i +: 16])),
                 longint'($signed(c[32*i +: 32])), 32, o, r, s);
        res[32*i +: 32] = r[31:0];
        sat |= s;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        lane_mdl(longint'($signed(a[32*i +: 32])), longint'($signed(b[32*i +: 32])),
                 longint'($signed(c[64*i +: 64])), 64, o, r, s);
        res[64*i +: 64] = r[63:0];
        sat |= s;
      end
    end
  endfunction

  task automatic issue(input logic [3:0] o, input logic [1:0] sz, input logic u,
                       input logic [63:0] a, input logic [63:0] b, input logic [127:0] c,
                       input logic clr);
    @(negedge clk);
    op = o; size = sz; uns = u; src_a = a; src_b = b; acc = c;
    sat_clr = clr; in_valid = 1;
    @(negedge clk);
    in_valid = 0; sat_clr = 0;
  endtask

  longint v16[8] = '{-32768, -32767, -1, 0, 1, 2, 32767, -12345};
  longint v32[8] = '{-64'sd2147483648, -64'sd2147483647, -1, 0, 1, 3, 64'sd2147483647, 123456789};
  longint a32s[4] = '{0, 64'sd2147483647, -64'sd2147483648, -1000};
  longint a64s[4] = '{0, 64'h7fffffffffffffff, 64'h8000000000000000, 987654321};

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] exp_r;
    logic exp_s;
    logic [3:0] ops[3];
    ops[0] = OP_MUL; ops[1] = OP_MLA; ops[2] = OP_MLS;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 0 && result == 0 && undef == 0 && sat_flag == 0, "R10",
          {out_valid, undef, sat_flag, result[31:0]}, 0);
    rst_n = 1;

    // R1 R3 R4 R5 R6 R7: sweep of both lane sizes
    for (int sz = 1; sz <= 2; sz++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 3; k++) begin
              logic [63:0] a, b;
              logic [127:0] c;
              if (sz == 1) begin
                a = {v16[(i+5)%8][15:0], v16[(j+1)%8][15:0], v16[j][15:0], v16[i][15:0]};
                b = {v16[(j+2)%8][15:0], v16[(i+3)%8][15:0], v16[i][15:0], v16[j][15:0]};
                c = {a32s[(p+3)%4][31:0], a32s[(p+2)%4][31:0], a32s[(p+1)%4][31:0], a32s[p][31:0]};
              end else begin
                a = {v32[j][31:0], v32[i][31:0]};
                b = {v32[(i+3)%8][31:0], v32[j][31:0]};
                c = {a64s[(p+1)%4], a64s[p]};
              end
              vec_mdl(ops[k], 2'(sz), a, b, c, exp_r, exp_s);
              issue(ops[k], 2'(sz), 1'b0, a, b, c, 1'b1);
              check(result == exp_r, "R1/R3/R4/R5/R6 result", result, exp_r);
              check(sat_flag == exp_s && undef == 0 && out_valid == 1, "R7 flag/R2 legal",
                    {out_valid, undef, sat_flag}, {2'b10, exp_s});
            end
          end
        end
      end
    end

    // R4: min*min doubling saturates to max
    issue(OP_MUL, 2'd1, 0, 64'h0000000000008000, 64'h0000000000008000, 0, 1);
    check(result[31:0] == 32'h7fffffff && sat_flag == 1, "R4 narrow", result, 128'h7fffffff);
    issue(OP_MUL, 2'd2, 0, 64'h80000000, 64'h80000000, 0, 1);
    check(result[63:0] == 64'h7fffffffffffffff && sat_flag == 1, "R4 wide", result, 128'h7fffffffffffffff);

    // R2: undefined combinations, flag untouched
    issue(OP_MUL, 2'd1, 0, 0, 0, 0, 1);
    check(sat_flag == 0, "R8 clear", sat_flag, 0);
    issue(OP_MLA, 2'd1, 1, 64'h8000, 64'h8000, 0, 0);
    check(undef == 1 && result == 0 && sat_flag == 0, "R2 uns", {undef, sat_flag, result[31:0]}, {2'b10, 32'h0});
    issue(OP_MUL, 2'd0, 0, 64'h8000, 64'h8000, 0, 0);
    check(undef == 1 && result == 0 && sat_flag == 0, "R2 size0", {undef, sat_flag, result[31:0]}, {2'b10, 32'h0});
    issue(OP_MUL, 2'd3, 0, 64'h8000, 64'h8000, 0, 0);
    check(undef == 1 && result == 0 && sat_flag == 0, "R2 size3", {undef, sat_flag, result[31:0]}, {2'b10, 32'h0});
    issue(4'b1000, 2'd1, 0, 64'h8000, 64'h8000, 0, 0);
    check(undef == 1 && result == 0 && sat_flag == 0, "R2 opcode", {undef, sat_flag, result[31:0]}, {2'b10, 32'h0});
    issue(4'b1100, 2'd2, 0, 64'h80000000, 64'h80000000, 0, 0);
    check(undef == 1 && result == 0 && sat_flag == 0, "R2 opcode wide", {undef, sat_flag, result[31:0]}, {2'b10, 32'h0});

    // R8: sticky flag
    issue(OP_MUL, 2'd1, 0, 64'h8000, 64'h8000, 0, 0);
    check(sat_flag == 1, "R7 set", sat_flag, 1);
    issue(OP_MUL, 2'd1, 0, 64'h3, 64'h4, 0, 0);
    check(sat_flag == 1 && result[31:0] == 32'd24, "R8 sticky", {sat_flag, result[31:0]}, {1'b1, 32'd24});
    @(negedge clk);
    sat_clr = 1;
    @(negedge clk);
    sat_clr = 0;
    check(sat_flag == 0, "R8 clear idle", sat_flag, 0);

    // R9: latency and hold
    issue(OP_MLA, 2'd1, 0, 64'h5, 64'h7, 128'd1, 0);
    check(out_valid == 1 && result[31:0] == 32'd71, "R9 latency", {out_valid, result[31:0]}, {1'b1, 32'd71});
    @(negedge clk);
    check(out_valid == 0 && result[31:0] == 32'd71 && undef == 0, "R9 hold", {out_valid, result[31:0]}, {1'b0, 32'd71});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule